// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block rebuilds the four integer condition flags (negative, zero, overflow, carry) of a 32-bit datapath from a small saved record: an operation code, the result word and the source operand word. The execution stage stores only that record, and the flags are computed when something actually needs them. The first operand is not stored. Each rule recovers it arithmetically from the result and the source, then derives carry and overflow from the recovered value.

The block also holds the arithmetic units for add-with-extend and subtract-with-extend. These take two operands and the incoming extend bit. They produce the sum or difference, the new extend bit and the flag nibble. The zero flag is made sticky, which lets a chain of word-sized operations report zero only if every word was zero. All outputs are registered one cycle after an accepted request. An unknown operation code raises a one-cycle error strobe and changes nothing else.

Top module: `lazy_ccr_unit`

## Requirements
- R1: After reset, `flags_out`, `x_out`, `sum_out`, `out_valid` and `bad_mode` are all zero.
- R2: A request with `in_valid` high and a legal `mode` (0 to 10) gives `out_valid` high on the next cycle, with the outputs updated at that same edge.
- R3: Mode 0 (pass) copies `data_a` unchanged into `flags_out`.
- R4: Outside mode 0, the flag nibble is placed in bits [3:0] of `flags_out` as N=bit 3, Z=bit 2, V=bit 1, C=bit 0, and all higher bits are zero. Z means the evaluated result is zero. N means it is nonzero with its top bit set. Mode 1 (logic) sets only N and Z, and clears V and C.
- R5: Mode 2 (add) treats `data_a` as the result of an addition and `data_b` as its second operand. C is the carry out and V is the signed overflow of that addition.
- R6: Mode 3 (subtract) treats `data_a` as the difference and `data_b` as the subtrahend. C is the borrow and V is the signed overflow of that subtraction.
- R7: Modes 4 and 5 apply the subtract rule to the low 8 and 16 bits of both words respectively, with N and Z taken from the truncated result. Higher bits have no effect.
- R8: Mode 6 evaluates an addition that included an incoming carry of one, and mode 7 a subtraction that included an incoming borrow of one. C and V follow the full carry or borrow of that operation.
- R9: Mode 8 (shift) takes N and Z from `data_a` and sets C exactly when `data_b` is nonzero.
- R10: Modes 9 and 10 compute `data_a + data_b + x_in` and `data_a - data_b - x_in` on `sum_out`, with `x_out` equal to the carry or borrow out. Modes 0 to 8 copy `x_in` to `x_out` and leave `sum_out` unchanged.
- R11: In modes 9 and 10 the reported Z is the zero test of the new sum ANDed with `prev_z`, so Z can only be cleared.
- R12: In modes 9 and 10 with `x_in` low, the result and flags equal those of a plain add or subtract.
- R13: A request with `mode` 11 to 15 raises `bad_mode` for exactly one cycle with `out_valid` low, and leaves `flags_out`, `x_out` and `sum_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | Operation select (0 to 10 legal) |
| data_a | input | DATA_W | Saved result, or first operand in modes 9 and 10 |
| data_b | input | DATA_W | Saved source, or second operand in modes 9 and 10 |
| x_in | input | 1 | Incoming extend bit |
| prev_z | input | 1 | Zero bit of the previously packed flags |
| out_valid | output | 1 | Result of a legal request is present |
| flags_out | output | DATA_W | Packed flags, or the raw word in pass mode |
| x_out | output | 1 | Extend bit after the request |
| sum_out | output | DATA_W | Result of the extended arithmetic units |
| bad_mode | output | 1 | One-cycle strobe for an illegal mode |

## Verification
The rules that recover the first operand are driven with operand pairs whose true carry and overflow the bench computes directly with wide arithmetic. The operand pairs are: small values with no carry, all-ones plus one, the largest positive value plus one, two negative extremes, and equal operands. Together they separate a carry-only case, an overflow-only case, both at once, and a zero result. The compare modes are driven with junk in the upper bits, and with low fields that overflow at 8 or 16 bits but not at 32. This shows whether the truncation width is right. The extended units are run as a two-word chain with `prev_z` set and then cleared. A separate pair with `x_in` low tells an off-by-one in the extend handling apart from a plain add or subtract.

// File: rtl/lazy_ccr_pkg.sv
package lazy_ccr_pkg;

    typedef enum logic [3:0] {
        OP_PASS   = 4'd0,
        OP_LOGIC  = 4'd1,
        OP_ADD    = 4'd2,
        OP_SUB    = 4'd3,
        OP_CMP8   = 4'd4,
        OP_CMP16  = 4'd5,
        OP_ADDC   = 4'd6,
        OP_SUBC   = 4'd7,
        OP_SHIFT  = 4'd8,
        OP_XADD   = 4'd9,
        OP_XSUB   = 4'd10
    } op_e;

    localparam int FLAG_W = 4;
    localparam int BIT_C  = 0;
    localparam int BIT_V  = 1;
    localparam int BIT_Z  = 2;
    localparam int BIT_N  = 3;

    localparam int NUM_SUB_LANES = 3;

    function automatic logic op_legal(input logic [3:0] code);
        return code <= OP_XSUB;
    endfunction

    function automatic logic op_is_exec(input logic [3:0] code);
        return (code == OP_XADD) || (code == OP_XSUB);
    endfunction

    function automatic logic [FLAG_W-1:0] pack_nzvc(input logic n, input logic z,
                                                   input logic v, input logic c);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[BIT_N] = n;
        f[BIT_Z] = z;
        f[BIT_V] = v;
        f[BIT_C] = c;
        return f;
    endfunction

endpackage

// File: rtl/lazy_ccr_add_rule.sv
// Flags of an addition rebuilt from its result r and its second operand s.
// With cin set the addition carried an extra one in.
module lazy_ccr_add_rule #(
    parameter int W = 32
) (
    input  logic [W-1:0] r,
    input  logic [W-1:0] s,
    input  logic         cin,
    output logic         n,
    output logic         z,
    output logic         v,
    output logic         c
);
    logic [W-1:0] first_op;
    logic [W-1:0] ovf_vec;

    always_comb begin
        first_op = r - s - {{(W-1){1'b0}}, cin};
        z        = (r == '0);
        n        = !z && r[W-1];
        c        = cin ? (r <= s) : (r < s);
        ovf_vec  = (s ^ r) & ~(first_op ^ s);
        v        = ovf_vec[W-1];
    end
endmodule

// File: rtl/lazy_ccr_sub_rule.sv
// Flags of a subtraction rebuilt from its difference r and subtrahend s.
// With cin set the subtraction took an extra one out.
module lazy_ccr_sub_rule #(
    parameter int W = 32
) (
    input  logic [W-1:0] r,
    input  logic [W-1:0] s,
    input  logic         cin,
    output logic         n,
    output logic         z,
    output logic         v,
    output logic         c
);
    logic [W-1:0] minuend;
    logic [W-1:0] ovf_vec;

    always_comb begin
        minuend = r + s + {{(W-1){1'b0}}, cin};
        z       = (r == '0);
        n       = !z && r[W-1];
        c       = cin ? (minuend <= s) : (minuend < s);
        ovf_vec = (minuend ^ r) & (minuend ^ s);
        v       = ovf_vec[W-1];
    end
endmodule

// File: rtl/lazy_ccr_ext_unit.sv
// Add or subtract with the extend bit folded in; produces the new extend bit.
module lazy_ccr_ext_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         x_cur,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         x_next
);
    logic [W-1:0] x_ext;

    always_comb begin
        x_ext = {{(W-1){1'b0}}, x_cur};
        if (do_sub) begin
            sum    = a - b - x_ext;
            x_next = x_cur ? (a <= b) : (a < b);
        end else begin
            sum    = a + b + x_ext;
            x_next = x_cur ? (sum <= b) : (sum < b);
        end
    end
endmodule

// File: rtl/lazy_ccr_unit.sv
module lazy_ccr_unit
    import lazy_ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] data_a,
    input  logic [DATA_W-1:0] data_b,
    input  logic              x_in,
    input  logic              prev_z,
    output logic              out_valid,
    output logic [DATA_W-1:0] flags_out,
    output logic              x_out,
    output logic [DATA_W-1:0] sum_out,
    output logic              bad_mode
);

    localparam int HI_W = DATA_W - FLAG_W;

    typedef struct packed {
        logic [DATA_W-1:0] flags;
        logic              x;
        logic [DATA_W-1:0] sum;
        logic              vld;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    // Operand steering shared by every flag rule
    logic [DATA_W-1:0] rule_r;
    logic [DATA_W-1:0] rule_s;
    logic              rule_cin;

    // Extended arithmetic unit
    logic [DATA_W-1:0] ext_sum;
    logic              ext_x;

    lazy_ccr_ext_unit #(.W(DATA_W)) u_ext (
        .a      (data_a),
        .b      (data_b),
        .x_cur  (x_in),
        .do_sub (mode == OP_XSUB),
        .sum    (ext_sum),
        .x_next (ext_x)
    );

    always_comb begin
        rule_r   = data_a;
        rule_s   = data_b;
        rule_cin = 1'b0;
        if (mode == OP_ADDC || mode == OP_SUBC) begin
            rule_cin = 1'b1;
        end else if (op_is_exec(mode)) begin
            rule_r   = ext_sum;
            rule_cin = x_in;
        end
    end

    // Add rule, full width
    logic add_n, add_z, add_v, add_c;

    lazy_ccr_add_rule #(.W(DATA_W)) u_add (
        .r   (rule_r),
        .s   (rule_s),
        .cin (rule_cin),
        .n   (add_n),
        .z   (add_z),
        .v   (add_v),
        .c   (add_c)
    );

    // Subtract rule in three lanes: byte, halfword, full width
    logic [NUM_SUB_LANES-1:0] sub_n, sub_z, sub_v, sub_c;

    for (genvar g = 0; g < NUM_SUB_LANES; g++) begin : g_sub_lane
        localparam int LW = (g == 0) ? 8 : ((g == 1) ? 16 : DATA_W);
        lazy_ccr_sub_rule #(.W(LW)) u_sub (
            .r   (rule_r[LW-1:0]),
            .s   (rule_s[LW-1:0]),
            .cin (rule_cin),
            .n   (sub_n[g]),
            .z   (sub_z[g]),
            .v   (sub_v[g]),
            .c   (sub_c[g])
        );
    end

    localparam int LANE_B = 0;
    localparam int LANE_H = 1;
    localparam int LANE_F = 2;

    // Next-state computation
    logic [FLAG_W-1:0] nib;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        nib      = '0;
        if (in_valid) begin
            if (!op_legal(mode)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.x   = x_in;
                unique case (op_e'(mode))
                    OP_PASS:  nib = '0;
                    OP_LOGIC: nib = pack_nzvc(sub_n[LANE_F], sub_z[LANE_F], 1'b0, 1'b0);
                    OP_ADD,
                    OP_ADDC:  nib = pack_nzvc(add_n, add_z, add_v, add_c);
                    OP_SUB,
                    OP_SUBC:  nib = pack_nzvc(sub_n[LANE_F], sub_z[LANE_F],
                                              sub_v[LANE_F], sub_c[LANE_F]);
                    OP_CMP8:  nib = pack_nzvc(sub_n[LANE_B], sub_z[LANE_B],
                                              sub_v[LANE_B], sub_c[LANE_B]);
                    OP_CMP16: nib = pack_nzvc(sub_n[LANE_H], sub_z[LANE_H],
                                              sub_v[LANE_H], sub_c[LANE_H]);
                    OP_SHIFT: nib = pack_nzvc(sub_n[LANE_F], sub_z[LANE_F],
                                              1'b0, data_b != '0);
                    OP_XADD:  nib = pack_nzvc(add_n, add_z && prev_z, add_v, add_c);
                    OP_XSUB:  nib = pack_nzvc(sub_n[LANE_F], sub_z[LANE_F] && prev_z,
                                              sub_v[LANE_F], sub_c[LANE_F]);
                    default:  nib = '0;
                endcase
                if (mode == OP_PASS) begin
                    st_d.flags = data_a;
                end else begin
                    st_d.flags = {{HI_W{1'b0}}, nib};
                end
                if (op_is_exec(mode)) begin
                    st_d.sum = ext_sum;
                    st_d.x   = ext_x;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign flags_out = st_q.flags;
    assign x_out     = st_q.x;
    assign sum_out   = st_q.sum;
    assign bad_mode  = st_q.err;

    // Assertions guarding the register stage

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(mode)) |=> out_valid)
        else $error("legal request without out_valid");

    p_pass_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == OP_PASS) |=> (flags_out == $past(data_a)))
        else $error("pass mode altered word");

    p_high_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(mode) && mode != OP_PASS) |=> (flags_out[DATA_W-1:FLAG_W] == '0))
        else $error("upper flag bits set");

    p_nz_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(mode) && mode != OP_PASS) |=> !(flags_out[BIT_N] && flags_out[BIT_Z]))
        else $error("N and Z both set");

    p_x_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(mode) && !op_is_exec(mode)) |=> (x_out == $past(x_in) && $stable(sum_out)))
        else $error("evaluation mode disturbed x or sum");

    p_sticky_z_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_exec(mode) && !prev_z) |=> !flags_out[BIT_Z])
        else $error("sticky zero was set");

    p_bad_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_legal(mode)) |=> (bad_mode && !out_valid && $stable(flags_out)
                                           && $stable(x_out) && $stable(sum_out)))
        else $error("illegal mode changed state");

endmodule

// File: tb/lazy_ccr_unit_tb.sv
`timescale 1ns/100ps
module lazy_ccr_unit_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    mode = '0;
    logic [DW-1:0] data_a = '0;
    logic [DW-1:0] data_b = '0;
    logic          x_in = 1'b0;
    logic          prev_z = 1'b0;
    logic          out_valid;
    logic [DW-1:0] flags_out;
    logic          x_out;
    logic [DW-1:0] sum_out;
    logic          bad_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lazy_ccr_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .data_a(data_a), .data_b(data_b), .x_in(x_in), .prev_z(prev_z),
        .out_valid(out_valid), .flags_out(flags_out), .x_out(x_out),
        .sum_out(sum_out), .bad_mode(bad_mode)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference flags of a w-bit add: {N,Z,V,C}, from true wide arithmetic
    function automatic logic [3:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                           input logic cin, input int w, output logic [31:0] r);
        logic [32:0] m, t;
        logic n, z, v, c;
        m = (33'd1 << w) - 33'd1;
        t = ({1'b0, a} & m) + ({1'b0, b} & m) + {32'd0, cin};
        r = t[31:0] & m[31:0];
        c = t[w];
        z = (r == 0);
        n = !z && r[w-1];
        v = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
        return {n, z, v, c};
    endfunction

    function automatic logic [3:0] ref_sub(input logic [31:0] a, input logic [31:0] b,
                                           input logic cin, input int w, output logic [31:0] r);
        logic [32:0] m, t;
        logic n, z, v, c;
        m = (33'd1 << w) - 33'd1;
        t = ({1'b0, a} & m) - ({1'b0, b} & m) - {32'd0, cin};
        r = t[31:0] & m[31:0];
        c = t[w];
        z = (r == 0);
        n = !z && r[w-1];
        v = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
        return {n, z, v, c};
    endfunction

    // Drive one request at a falling edge; outputs are valid at the next falling edge
    task automatic apply(input logic [3:0] m, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic xi, input logic pz);
        @(negedge clk);
        in_valid = 1'b1; mode = m; data_a = a; data_b = b; x_in = xi; prev_z = pz;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] nib(input logic [3:0] f);
        return {28'd0, f};
    endfunction

    task automatic t_reset();
        check("R1 flags", flags_out, '0);
        check("R1 x", {31'd0, x_out}, '0);
        check("R1 sum", sum_out, '0);
        check("R1 valid", {31'd0, out_valid}, '0);
        check("R1 bad", {31'd0, bad_mode}, '0);
    endtask

    task automatic t_pass();
        apply(4'd0, 32'hDEAD_BEEF, 32'h1, 1'b0, 1'b0);
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        check("R3 pass", flags_out, 32'hDEAD_BEEF);
    endtask

    task automatic t_logic();
        apply(4'd1, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R4 logic zero", flags_out, nib(4'b0100));
        apply(4'd1, 32'h8000_0001, 32'h0, 1'b0, 1'b0);
        check("R4 logic neg", flags_out, nib(4'b1000));
        apply(4'd1, 32'h7000_0000, 32'h1, 1'b0, 1'b0);
        check("R4 logic pos", flags_out, nib(4'b0000));
    endtask

    task automatic t_add();
        logic [31:0] va [5] = '{32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0};
        logic [31:0] vb [5] = '{32'h1, 32'h1, 32'h1, 32'h8000_0000, 32'h0};
        for (int i = 0; i < 5; i++) begin
            logic [31:0] r;
            logic [3:0] f;
            f = ref_add(va[i], vb[i], 1'b0, 32, r);
            apply(4'd2, r, vb[i], 1'b0, 1'b0);
            check($sformatf("R5 add %0d", i), flags_out, nib(f));
        end
    endtask

    task automatic t_sub();
        logic [31:0] va [5] = '{32'h5, 32'h0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};
        logic [31:0] vb [5] = '{32'h3, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h1234_5678};
        for (int i = 0; i < 5; i++) begin
            logic [31:0] r;
            logic [3:0] f;
            f = ref_sub(va[i], vb[i], 1'b0, 32, r);
            apply(4'd3, r, vb[i], 1'b0, 1'b0);
            check($sformatf("R6 sub %0d", i), flags_out, nib(f));
        end
    endtask

    task automatic t_cmp();
        logic [31:0] r;
        logic [3:0] f;
        // byte: 0x80 - 0x01 overflows at 8 bits; upper bits are junk
        f = ref_sub(32'h80, 32'h01, 1'b0, 8, r);
        apply(4'd4, 32'hA5A5_A500 | r, 32'h5A5A_5A01, 1'b0, 1'b0);
        check("R7 cmp8 ovf", flags_out, nib(f));
        f = ref_sub(32'h10, 32'h10, 1'b0, 8, r);
        apply(4'd4, 32'hFFFF_FF00 | r, 32'h0000_1210, 1'b0, 1'b0);
        check("R7 cmp8 zero", flags_out, nib(f));
        f = ref_sub(32'h0, 32'h1, 1'b0, 16, r);
        apply(4'd5, 32'h7777_0000 | r, 32'h0003_0001, 1'b0, 1'b0);
        check("R7 cmp16 borrow", flags_out, nib(f));
    endtask

    task automatic t_carry_eval();
        logic [31:0] r;
        logic [3:0] f;
        f = ref_add(32'hFFFF_FFFF, 32'h0, 1'b1, 32, r);
        apply(4'd6, r, 32'h0, 1'b0, 1'b0);
        check("R8 addc wrap", flags_out, nib(f));
        f = ref_add(32'h7FFF_FFFE, 32'h1, 1'b1, 32, r);
        apply(4'd6, r, 32'h1, 1'b0, 1'b0);
        check("R8 addc ovf", flags_out, nib(f));
        f = ref_sub(32'h5, 32'h5, 1'b1, 32, r);
        apply(4'd7, r, 32'h5, 1'b0, 1'b0);
        check("R8 subc equal", flags_out, nib(f));
        f = ref_sub(32'h9, 32'h3, 1'b1, 32, r);
        apply(4'd7, r, 32'h3, 1'b0, 1'b0);
        check("R8 subc plain", flags_out, nib(f));
    endtask

    task automatic t_shift();
        apply(4'd8, 32'h8000_0000, 32'h1, 1'b0, 1'b0);
        check("R9 shift neg carry", flags_out, nib(4'b1001));
        apply(4'd8, 32'h0, 32'h0, 1'b0, 1'b0);
        check("R9 shift zero", flags_out, nib(4'b0100));
    endtask

    task automatic t_exec_chain();
        logic [31:0] r;
        logic [3:0] f;
        // Low word: 0xFFFFFFFF + 1 with x=0 (plain add, R12)
        f = ref_add(32'hFFFF_FFFF, 32'h1, 1'b0, 32, r);
        apply(4'd9, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        check("R12 xadd plain flags", flags_out, nib(f));
        check("R10 xadd sum", sum_out, r);
        check("R10 xadd x", {31'd0, x_out}, {31'd0, f[0]});
        // High word with carry: 0xFFFFFFFF + 0 + 1 -> zero, prev Z clear -> Z stays clear
        f = ref_add(32'hFFFF_FFFF, 32'h0, 1'b1, 32, r);
        f[2] = f[2] & 1'b0;
        apply(4'd9, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
        check("R11 xadd sticky clear", flags_out, nib(f));
        check("R10 xadd sum hi", sum_out, 32'h0);
        // Same, prev Z set -> Z reported
        f = ref_add(32'hFFFF_FFFF, 32'h0, 1'b1, 32, r);
        apply(4'd9, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1);
        check("R11 xadd zero kept", flags_out, nib(f));
        // Subtract with borrow in: 3 - 3 - 1
        f = ref_sub(32'h3, 32'h3, 1'b1, 32, r);
        apply(4'd10, 32'h3, 32'h3, 1'b1, 1'b1);
        check("R10 xsub flags", flags_out, nib(f));
        check("R10 xsub sum", sum_out, r);
        check("R10 xsub x", {31'd0, x_out}, {31'd0, f[0]});
        // Subtract with no borrow in: 7 - 7
        f = ref_sub(32'h7, 32'h7, 1'b0, 32, r);
        apply(4'd10, 32'h7, 32'h7, 1'b0, 1'b1);
        check("R12 xsub plain", flags_out, nib(f));
        check("R12 xsub sum", sum_out, 32'h0);
    endtask

    task automatic t_eval_x();
        // sum_out currently 0 from last chain step; eval mode with x_in=1
        apply(4'd1, 32'h5, 32'h0, 1'b1, 1'b0);
        check("R10 eval copies x", {31'd0, x_out}, 32'd1);
        check("R10 eval keeps sum", sum_out, 32'h0);
    endtask

    task automatic t_bad();
        logic [DW-1:0] f0, s0;
        logic x0;
        apply(4'd8, 32'h8000_0000, 32'h1, 1'b1, 1'b0);
        f0 = flags_out; s0 = sum_out; x0 = x_out;
        apply(4'd12, 32'h0, 32'h0, 1'b0, 1'b1);
        check("R13 bad strobe", {31'd0, bad_mode}, 32'd1);
        check("R13 no valid", {31'd0, out_valid}, 32'd0);
        check("R13 flags held", flags_out, f0);
        check("R13 x held", {31'd0, x_out}, {31'd0, x0});
        check("R13 sum held", sum_out, s0);
        @(negedge clk);
        check("R13 one cycle", {31'd0, bad_mode}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass();
        t_logic();
        t_add();
        t_sub();
        t_cmp();
        t_carry_eval();
        t_shift();
        t_exec_chain();
        t_eval_x();
        t_bad();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule